// File: doc/BRIEF.md
# Raster Video Register and Interrupt Unit

This block is the register bank of a raster video controller, addressed as bytes from a CPU bus. It runs the horizontal and vertical raster counters, flags the visible area and the vertical blank, and holds an interrupt mask, a general control byte and an unlock sequencer. The sequencer moves the controller out of its legacy register mode into its extended mode.

Once per frame, at the first clock of vertical blank, the block can latch a CPU interrupt. The interrupt stays pending until the CPU acknowledges it. Bit 0 of the control byte also decides where a 1 KB I/O window of the CPU address space goes. When the bit is set, the window reaches colour RAM. When it is clear, the window reaches the peripheral chips, and the window read data then returns 0xFF because nothing backs it here.

Top module: `raster_reg_unit`

## Requirements
- R1: While reset is asserted and after it is released, the raster position is (0,0), the mask and control byte are 0, the controller is in legacy mode and the interrupt output is low.
- R2: The horizontal count steps by one each clock from 0 to H_TOTAL-1 and then wraps to 0. The vertical count advances only on that wrap, counts from 0 to V_TOTAL-1 and then wraps to 0.
- R3: `display_active` is high exactly when the horizontal count is below H_VIS and the vertical count is below V_VIS. `vblank` is high exactly when the vertical count is V_VIS or more.
- R4: A read at register offset 0x12 returns the low 8 bits of the vertical count.
- R5: A write at offset 0x1A stores data bits 3:0 as the mask. A read there returns the mask in bits 3:0, with bits 7:4 at zero.
- R6: A write at offset 0x30 stores all 8 bits of the control byte. A read there returns the last value written.
- R7: Writes at the key offset 0x2F enter the extended mode when the value 0xA5 is followed by the value 0x96 as the next write to that offset. `ext_mode` goes high on the clock after the second write, and a read at 0x2F returns the mode in bit 0. Writes to other offsets between the two key writes do not break the sequence.
- R8: Any other key write leaves the controller in legacy mode, or returns it there. This covers 0xA5 followed by a value other than 0x96. A write of 0xA5 always starts a new sequence.
- R9: For window addresses 0xDC00 to 0xDFFF, when control bit 0 is 1, `cram_sel` is high and `win_rdata` equals `cram_rdata`. When control bit 0 is 0, `periph_sel` is high and `win_rdata` is 0xFF. For any other address both selects are low and `win_rdata` is 0xFF.
- R10: `irq` rises on the clock on which the raster moves from the last clock of line V_VIS-1 to line V_VIS. This happens only if mask bit 0 is set at that moment. Mask bits 3:1 have no effect on it.
- R11: `irq` stays high until a clock with `irq_ack` high clears it. When a new vertical-blank event and an acknowledge fall on the same clock, the event wins.
- R12: Reads at offsets that are not mapped return 0xFF. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_cs | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when high, read when low |
| reg_addr | input | 7 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| win_addr | input | 16 | CPU address checked against the I/O window |
| cram_rdata | input | 8 | Data returned by colour RAM |
| cram_sel | output | 1 | Window access goes to colour RAM |
| periph_sel | output | 1 | Window access goes to peripheral chips |
| win_rdata | output | 8 | Read data for the window |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| irq | output | 1 | Pending vertical-blank interrupt |
| ext_mode | output | 1 | Extended register mode active |
| raster_x | output | XW | Horizontal count |
| raster_y | output | YW | Vertical count |
| display_active | output | 1 | Inside the visible area |
| vblank | output | 1 | Inside vertical blank |

## Verification
The hardest case to reach from the ports is an acknowledge that arrives on the very clock of a new vertical-blank event. A second hard case is an unlock sequence with an unrelated register write between its two key writes.

The bench keeps its own model of the raster position. It uses that model to wait for the last clock of the line before blank, drives the acknowledge exactly there, and then checks that the interrupt is still pending. Random register traffic leans towards the two key values, so that armed, confirmed and broken sequences all occur among mask and control writes.

// File: rtl/rvc_pkg.sv
package rvc_pkg;

  typedef enum logic [1:0] {
    KS_LEGACY = 2'd0,
    KS_ARMED  = 2'd1,
    KS_EXT    = 2'd2
  } key_state_t;

  localparam logic [6:0] OFS_LINE = 7'h12;
  localparam logic [6:0] OFS_MASK = 7'h1A;
  localparam logic [6:0] OFS_KEY  = 7'h2F;
  localparam logic [6:0] OFS_CTLA = 7'h30;

  localparam logic [7:0] KEY_OPEN    = 8'hA5;
  localparam logic [7:0] KEY_CONFIRM = 8'h96;
  localparam logic [7:0] RD_IDLE     = 8'hFF;

  // Next unlock state after one write to the key offset.
  function automatic key_state_t key_step(key_state_t cur, logic [7:0] d);
    if (d == KEY_OPEN) return KS_ARMED;
    if (cur == KS_ARMED && d == KEY_CONFIRM) return KS_EXT;
    return KS_LEGACY;
  endfunction

  // 1 KB I/O window at 0xDC00..0xDFFF: the top six address bits are 110111.
  function automatic logic in_io_window(logic [15:0] a);
    return a[15:10] == 6'b110111;
  endfunction

endpackage

// File: rtl/raster_timer.sv
module raster_timer #(
  parameter int H_TOTAL = 910,
  parameter int V_TOTAL = 525,
  parameter int H_VIS   = 320,
  parameter int V_VIS   = 240,
  parameter int XW      = $clog2(H_TOTAL),
  parameter int YW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y,
  output logic          line_end,
  output logic          vblank_start,
  output logic          display_active,
  output logic          vblank
);

  localparam logic [XW-1:0] X_LAST  = XW'(H_TOTAL - 1);
  localparam logic [YW-1:0] Y_LAST  = YW'(V_TOTAL - 1);
  localparam logic [YW-1:0] Y_PRE   = YW'(V_VIS - 1);
  localparam logic [XW-1:0] X_VISLM = XW'(H_VIS);
  localparam logic [YW-1:0] Y_VISLM = YW'(V_VIS);

  assign line_end       = (x == X_LAST);
  assign vblank_start   = line_end && (y == Y_PRE);
  assign display_active = (x < X_VISLM) && (y < Y_VISLM);
  assign vblank         = (y >= Y_VISLM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x <= '0;
      y <= '0;
    end else begin
      x <= line_end ? '0 : x + 1'b1;
      if (line_end) y <= (y == Y_LAST) ? '0 : y + 1'b1;
    end
  end

  a_r2_x_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (x == '0));
  a_r2_x_step: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> (x == $past(x) + 1'b1));
  a_r2_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(y));
  a_r2_y_range: assert property (@(posedge clk) disable iff (!rst_n)
    y <= Y_LAST);

endmodule

// File: rtl/key_seq.sv
module key_seq
  import rvc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  output logic       ext_mode
);

  key_state_t state;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= KS_LEGACY;
    else if (key_wr) state <= key_step(state, key_data);
  end

  assign ext_mode = (state == KS_EXT);

  a_r7_confirm: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_data == KEY_CONFIRM && state == KS_ARMED) |=> ext_mode);
  a_r8_other_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_data != KEY_CONFIRM) |=> !ext_mode);
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(ext_mode));

endmodule

// File: rtl/irq_latch.sv
module irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic enable,
  input  logic ack,
  output logic irq
);

  logic fire;
  assign fire = set_evt && enable;

  always_ff @(posedge clk) begin
    if (!rst_n)   irq <= 1'b0;
    else if (fire) irq <= 1'b1;
    else if (ack)  irq <= 1'b0;
  end

  a_r10_raise: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> irq);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !fire) |=> !irq);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq);
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ack && !fire) |=> !irq);

endmodule

// File: rtl/raster_reg_unit.sv
module raster_reg_unit
  import rvc_pkg::*;
#(
  parameter int H_TOTAL = 910,
  parameter int V_TOTAL = 525,
  parameter int H_VIS   = 320,
  parameter int V_VIS   = 240,
  localparam int XW     = $clog2(H_TOTAL),
  localparam int YW     = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_cs,
  input  logic          reg_we,
  input  logic [6:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [15:0]   win_addr,
  input  logic [7:0]    cram_rdata,
  output logic          cram_sel,
  output logic          periph_sel,
  output logic [7:0]    win_rdata,
  input  logic          irq_ack,
  output logic          irq,
  output logic          ext_mode,
  output logic [XW-1:0] raster_x,
  output logic [YW-1:0] raster_y,
  output logic          display_active,
  output logic          vblank
);

  logic [3:0] mask_q;
  logic [7:0] ctla_q;
  logic       line_end, vblank_start;
  logic       wr_mask, wr_ctla, wr_key, win_hit;

  assign wr_mask = reg_cs && reg_we && (reg_addr == OFS_MASK);
  assign wr_ctla = reg_cs && reg_we && (reg_addr == OFS_CTLA);
  assign wr_key  = reg_cs && reg_we && (reg_addr == OFS_KEY);

  raster_timer #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .H_VIS(H_VIS), .V_VIS(V_VIS),
    .XW(XW), .YW(YW)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .x(raster_x), .y(raster_y),
    .line_end(line_end), .vblank_start(vblank_start),
    .display_active(display_active), .vblank(vblank)
  );

  key_seq u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(wr_key), .key_data(reg_wdata),
    .ext_mode(ext_mode)
  );

  irq_latch u_irq (
    .clk(clk), .rst_n(rst_n), .set_evt(vblank_start), .enable(mask_q[0]),
    .ack(irq_ack), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      ctla_q <= '0;
    end else begin
      if (wr_mask) mask_q <= reg_wdata[3:0];
      if (wr_ctla) ctla_q <= reg_wdata;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_LINE: reg_rdata = 8'(raster_y);
      OFS_MASK: reg_rdata = {4'b0000, mask_q};
      OFS_KEY:  reg_rdata = {7'b0000000, ext_mode};
      OFS_CTLA: reg_rdata = ctla_q;
      default:  reg_rdata = RD_IDLE;
    endcase
  end

  assign win_hit    = in_io_window(win_addr);
  assign cram_sel   = win_hit && ctla_q[0];
  assign periph_sel = win_hit && !ctla_q[0];
  assign win_rdata  = cram_sel ? cram_rdata : RD_IDLE;

  a_r6_ctla_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctla |=> (ctla_q == $past(reg_wdata)));
  a_r5_mask_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(reg_wdata[3:0])));
  a_r9_periph_idle: assert property (@(posedge clk) disable iff (!rst_n)
    periph_sel |-> (win_rdata == 8'hFF && !cram_sel));
  a_r12_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_cs && reg_we) |=> ($stable(mask_q) && $stable(ctla_q)));

endmodule

// File: tb/tb_raster_reg_unit.sv
`timescale 1ns/100ps
module tb_raster_reg_unit;

  localparam int HT = 16, VT = 10, HV = 6, VV = 5;
  localparam int XW = $clog2(HT), YW = $clog2(VT);

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_cs = 0, reg_we = 0, irq_ack = 0;
  logic [6:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, cram_rdata = '0, reg_rdata, win_rdata;
  logic [15:0] win_addr = '0;
  logic cram_sel, periph_sel, irq, ext_mode, display_active, vblank;
  logic [XW-1:0] raster_x;
  logic [YW-1:0] raster_y;

  int total = 0, bad = 0;
  bit mon_on = 0, done = 0;

  // bench model state
  int mx = 0, my = 0, mks = 0;
  logic [3:0] mmask = 0;
  logic [7:0] mctl = 0;
  bit mirq = 0;

  always #2.5 clk = ~clk;

  raster_reg_unit #(.H_TOTAL(HT), .V_TOTAL(VT), .H_VIS(HV), .V_VIS(VV)) dut (
    .clk(clk), .rst_n(rst_n), .reg_cs(reg_cs), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .win_addr(win_addr), .cram_rdata(cram_rdata), .cram_sel(cram_sel),
    .periph_sel(periph_sel), .win_rdata(win_rdata), .irq_ack(irq_ack),
    .irq(irq), .ext_mode(ext_mode), .raster_x(raster_x), .raster_y(raster_y),
    .display_active(display_active), .vblank(vblank));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, written from the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      mx <= 0; my <= 0; mks <= 0; mmask <= 0; mctl <= 0; mirq <= 0;
    end else begin
      if (mx == HT - 1 && my == VV - 1 && mmask[0]) mirq <= 1;
      else if (irq_ack) mirq <= 0;
      if (mx == HT - 1) begin
        mx <= 0;
        my <= (my + 1) % VT;
      end else mx <= mx + 1;
      if (reg_cs && reg_we) begin
        if (reg_addr == 7'h1A) mmask <= reg_wdata[3:0];
        if (reg_addr == 7'h30) mctl <= reg_wdata;
        if (reg_addr == 7'h2F)
          mks <= (reg_wdata == 8'hA5) ? 1 : ((mks == 1 && reg_wdata == 8'h96) ? 2 : 0);
      end
    end
  end

  function automatic bit exp_active(int x, int y);
    return (x < HV) && (y < VV);
  endfunction

  function automatic bit exp_hit(logic [15:0] a);
    return (a >= 16'hDC00) && (a <= 16'hDFFF);
  endfunction

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      chk(int'(raster_x) == mx, "R2 raster_x", int'(raster_x), mx);
      chk(int'(raster_y) == my, "R2 raster_y", int'(raster_y), my);
      chk(display_active == exp_active(mx, my), "R3 display_active", display_active, exp_active(mx, my));
      chk(vblank == (my >= VV), "R3 vblank", vblank, my >= VV);
      chk(irq == mirq, "R10/R11 irq", irq, mirq);
      chk(ext_mode == (mks == 2), "R7/R8 ext_mode", ext_mode, mks == 2);
    end
  end

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_cs = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_cs = 0; reg_we = 0;
  endtask

  task automatic rd_chk(input logic [6:0] a, input logic [7:0] exp, input string req);
    reg_addr = a; reg_cs = 1; reg_we = 0;
    #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
    reg_cs = 0;
  endtask

  task automatic win_chk(input logic [15:0] a, input logic [7:0] cd);
    bit h;
    win_addr = a; cram_rdata = cd;
    #1;
    h = exp_hit(a);
    chk(cram_sel == (h && mctl[0]), "R9 cram_sel", cram_sel, h && mctl[0]);
    chk(periph_sel == (h && !mctl[0]), "R9 periph_sel", periph_sel, h && !mctl[0]);
    chk(win_rdata == ((h && mctl[0]) ? cd : 8'hFF), "R9 win_rdata", win_rdata,
        (h && mctl[0]) ? cd : 8'hFF);
  endtask

  initial begin
    #(5 * 30000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk(raster_x == 0 && raster_y == 0, "R1 position", {raster_x, raster_y}, 0);
    chk(!irq && !ext_mode, "R1 irq/mode", {irq, ext_mode}, 0);
    rst_n = 1;
    mon_on = 1;
    rd_chk(7'h1A, 8'h00, "R1 mask reset");
    rd_chk(7'h30, 8'h00, "R1 control reset");
    rd_chk(7'h2F, 8'h00, "R1 legacy mode");

    // R5 / R6
    wr(7'h1A, 8'hFE); rd_chk(7'h1A, 8'h0E, "R5 mask low nibble");
    wr(7'h30, 8'h5A); rd_chk(7'h30, 8'h5A, "R6 control readback");

    // R4 at several lines
    for (int i = 0; i < 5; i++) begin
      repeat (7 + i * 11) @(negedge clk);
      rd_chk(7'h12, 8'(my), "R4 line read");
    end

    // R7 / R8 key sequences
    wr(7'h2F, 8'hA5); wr(7'h2F, 8'h96);
    chk(ext_mode == 1, "R7 enter extended", ext_mode, 1);
    rd_chk(7'h2F, 8'h01, "R7 mode readback");
    wr(7'h2F, 8'h00);
    chk(ext_mode == 0, "R8 leave on other write", ext_mode, 0);
    wr(7'h2F, 8'hA5); wr(7'h2F, 8'h33);
    chk(ext_mode == 0, "R8 broken sequence", ext_mode, 0);
    wr(7'h2F, 8'h96);
    chk(ext_mode == 0, "R8 confirm without open", ext_mode, 0);
    wr(7'h2F, 8'hA5); wr(7'h2F, 8'hA5); wr(7'h2F, 8'h96);
    chk(ext_mode == 1, "R8 re-arm by open", ext_mode, 1);
    wr(7'h2F, 8'hA5);
    chk(ext_mode == 0, "R8 open leaves extended", ext_mode, 0);
    wr(7'h30, 8'h5B); wr(7'h2F, 8'h96);
    chk(ext_mode == 1, "R7 other offset in between", ext_mode, 1);

    // R12 unmapped offsets
    wr(7'h05, 8'h77); wr(7'h7F, 8'h01);
    rd_chk(7'h05, 8'hFF, "R12 unmapped read");
    rd_chk(7'h1A, 8'h0E, "R12 mask untouched");
    rd_chk(7'h30, 8'h5B, "R12 control untouched");

    // R9 window
    win_chk(16'hDC00, 8'h3C); win_chk(16'hDFFF, 8'hC3);
    win_chk(16'hDBFF, 8'h11); win_chk(16'hE000, 8'h22);
    wr(7'h30, 8'h00);
    win_chk(16'hDC00, 8'h3C); win_chk(16'hDE80, 8'h44);

    // R10: bits 3:1 alone never raise
    wr(7'h1A, 8'h0E);
    repeat (HT * VT + 4) @(negedge clk);
    chk(irq == 0, "R10 upper mask bits inert", irq, 0);

    // R10: raise timing
    wr(7'h1A, 8'h01);
    for (int i = 0; i < HT * VT + 4; i++) begin
      @(negedge clk);
      if (irq) break;
    end
    chk(irq == 1 && mx == 0 && my == VV, "R10 raise at blank start", {mx, my}, VV);
    repeat (30) @(negedge clk);
    chk(irq == 1, "R11 held until ack", irq, 1);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    chk(irq == 0, "R11 ack clears", irq, 0);

    // R11: ack on the same clock as the event
    for (int i = 0; i < HT * VT + 4; i++) begin
      @(negedge clk);
      if (mx == HT - 1 && my == VV - 1) break;
    end
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    chk(irq == 1, "R11 event beats ack", irq, 1);
    irq_ack = 1; @(negedge clk); irq_ack = 0;

    // random traffic
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [7:0] d;
      op = $urandom_range(0, 6);
      d = 8'($urandom);
      case (op)
        0: wr(7'h1A, d);
        1: wr(7'h30, d);
        2: wr(7'h2F, ($urandom_range(0, 2) == 0) ? d : (($urandom_range(0, 1) == 1) ? 8'hA5 : 8'h96));
        3: begin
          @(negedge clk);
          irq_ack = ($urandom_range(0, 3) == 0);
        end
        4: begin
          @(negedge clk);
          case ($urandom_range(0, 4))
            0: rd_chk(7'h12, 8'(my), "R4 random read");
            1: rd_chk(7'h1A, {4'b0, mmask}, "R5 random read");
            2: rd_chk(7'h30, mctl, "R6 random read");
            3: rd_chk(7'h2F, {7'b0, mks == 2}, "R7 random read");
            default: rd_chk(7'h40 + 7'($urandom_range(0, 63)), 8'hFF, "R12 random read");
          endcase
        end
        5: begin
          @(negedge clk);
          win_chk(16'hDA00 + 16'($urandom_range(0, 16'h0800)), d);
        end
        default: repeat ($urandom_range(1, 20)) @(negedge clk);
      endcase
    end
    @(negedge clk);
    irq_ack = 0;
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule